// File: doc/BRIEF.md
# Interrupt Request Latch

This block is the input stage of a two-unit cascaded interrupt controller. Each unit (a primary unit and a secondary unit) has eight request lines. Every line is brought into the clock domain and, depending on a per-line trigger-mode bit, is turned into a request-register bit. In edge mode a rising line latches a request that persists after the line drops. In level mode the request follows the line: a high line keeps it set and a falling line clears it.

Software writes and reads a byte-wide trigger-mode register for each unit through one configuration port, with a select input choosing the unit. Some lines are reserved as edge-only and can never be switched to level mode. Downstream priority logic reports a pending secondary request on `slv_pending_i`. The latch turns it into a one-cycle pulse on primary line 2, the cascade line, which the primary unit sees as a rising edge. An acknowledge input retires a request bit only if its line is low at that moment. Acknowledging a secondary line also acknowledges primary line 2.

Top module: `irq_req_latch`

## Requirements
- R1: On a line in edge mode (trigger bit 0), a low-to-high transition sets its request bit, and the bit stays set after the line returns low.
- R2: On a line in level mode (trigger bit 1), a high line sets its request bit and a high-to-low transition clears it.
- R3: A write to the primary trigger register (`cfg_unit_i` = 0) stores the data ANDed with 0xF8, so primary lines 0, 1 and 2 stay edge-only. A write to the secondary register (`cfg_unit_i` = 1) stores the data ANDed with 0xDE, so secondary lines 0 and 5 stay edge-only.
- R4: `cfg_rdata_o` shows, in the same cycle, the stored trigger register of the unit selected by `cfg_unit_i`. Bit n controls line n.
- R5: An acknowledge (`ack_i` with `ack_unit_i` and `ack_pin_i`) clears the addressed request bit only if that line is low in that cycle. If the line is high, or a rising edge arrives in the same cycle, the bit stays set.
- R6: Acknowledging any secondary line also acknowledges primary line 2, under the same line-low rule as R5.
- R7: While `slv_pending_i` is high and no cascade is outstanding, the block emits one single-cycle pulse on primary line 2, which sets primary request bit 2 as a rising edge. No further pulse is emitted until a secondary acknowledge.
- R8: A request bit reacts on the third rising clock edge after its input line changes (two synchroniser stages plus the request register).
- R9: Synchronous active-low reset clears all request bits and both trigger registers (0x00, every line edge-mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mst_pin_i | input | 8 | Primary unit request lines (asynchronous) |
| slv_pin_i | input | 8 | Secondary unit request lines (asynchronous) |
| cfg_we_i | input | 1 | Trigger-register write strobe |
| cfg_unit_i | input | 1 | Unit select for configuration: 0 primary, 1 secondary |
| cfg_wdata_i | input | 8 | Trigger-register write data |
| cfg_rdata_o | output | 8 | Stored trigger register of the selected unit |
| ack_i | input | 1 | Acknowledge strobe |
| ack_unit_i | input | 1 | Unit of the acknowledged line: 0 primary, 1 secondary |
| ack_pin_i | input | 3 | Line index being acknowledged |
| slv_pending_i | input | 1 | Secondary unit has an eligible request |
| mst_req_o | output | 8 | Primary request register |
| slv_req_o | output | 8 | Secondary request register |

## Verification
An acknowledge and a fresh rising edge can land on the same line in the same cycle. The bench provokes this by raising an edge-mode line and pulsing the acknowledge exactly on the clock edge where the synchronised rise reaches the request register. The bit must stay set, because a line that is high is never retired. A second collision is a secondary acknowledge that coincides with a still-pending secondary request. The bench judges that case by watching primary bit 2: it must stay clear while no acknowledge has come, and must return only after the acknowledge re-arms the cascade.

// File: rtl/irql_pkg.sv
// Package: shared constants and types for the interrupt request latch.
// Assumes two cascaded units of identical width.
package irql_pkg;

    typedef enum logic {
        UNIT_MST = 1'b0,
        UNIT_SLV = 1'b1
    } irql_unit_e;

    localparam int IRQL_NUNIT    = 2;
    localparam int IRQL_CASC_PIN = 2;

endpackage

// File: rtl/irql_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous lines.
// Assumes each line is quasi-static relative to the clock (no bus coherence).
module irql_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two flops in series bring the lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/irql_trig_reg.sv
// Module: per-unit trigger-mode registers with fixed edge-only lines.
// Assumes the read is combinational on the unit select; a write lands on the next edge.
module irql_trig_reg #(
    parameter int             NPIN   = 8,
    parameter logic [NPIN-1:0] MST_OK = 8'hF8,
    parameter logic [NPIN-1:0] SLV_OK = 8'hDE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic            unit_i,
    input  logic [NPIN-1:0] wdata_i,
    output logic [NPIN-1:0] rdata_o,
    output logic [NPIN-1:0] mst_lvl_o,
    output logic [NPIN-1:0] slv_lvl_o
);
    import irql_pkg::*;

    logic [NPIN-1:0] lvl_q [IRQL_NUNIT];

    for (genvar u = 0; u < IRQL_NUNIT; u++) begin : g_unit
        localparam logic [NPIN-1:0] ALLOW = (u == 0) ? MST_OK : SLV_OK;

        // Store the masked write data for the addressed unit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[u] <= '0;
            end else if (we_i && (unit_i == 1'(u))) begin
                lvl_q[u] <= wdata_i & ALLOW;
            end
        end

        AST_RSVD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_q[u] & ~ALLOW) == '0);                                   // R3
        AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (unit_i == 1'(u))) |=> $stable(lvl_q[u]));           // R4
    end

    assign mst_lvl_o = lvl_q[UNIT_MST];
    assign slv_lvl_o = lvl_q[UNIT_SLV];
    assign rdata_o   = (unit_i == UNIT_SLV) ? lvl_q[UNIT_SLV] : lvl_q[UNIT_MST];

endmodule

// File: rtl/irql_unit.sv
// Module: request register of one unit, edge or level per line.
// Assumes line_i is already synchronised; ack_vec_i is at most one-hot per line.
module irql_unit #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] line_i,
    input  logic [NPIN-1:0] lvl_i,
    input  logic [NPIN-1:0] ack_vec_i,
    output logic [NPIN-1:0] req_o
);

    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] req_q;
    logic [NPIN-1:0] req_nxt;

    for (genvar i = 0; i < NPIN; i++) begin : g_line
        logic rise, fall, set_b, clr_b;
        // Work out the set and clear terms of one line.
        always_comb begin
            rise  = line_i[i] & ~prev_q[i];
            fall  = ~line_i[i] & prev_q[i];
            set_b = rise | (line_i[i] & lvl_i[i]);
            clr_b = (fall & lvl_i[i]) | (ack_vec_i[i] & ~line_i[i]);
            req_nxt[i] = (req_q[i] | set_b) & ~clr_b;
        end
    end

    // Register the previous line value and the request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= line_i;
            req_q  <= req_nxt;
        end
    end

    assign req_o = req_q;

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(line_i & ~prev_q) & ~req_q) == '0));                      // R1
    AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_q & ~lvl_i & ~ack_vec_i) & ~req_q) == '0));          // R1
    AST_LVL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(lvl_i & prev_q & ~line_i) & req_q) == '0));              // R2
    AST_ACK_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_q & ack_vec_i & line_i) & ~req_q) == '0));           // R5
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec_i));                                                      // R5

endmodule

// File: rtl/irql_cascade.sv
// Module: turns a pending secondary request into a single pulse for the cascade line.
// Assumes slv_ack_i marks any acknowledge of a secondary line.
module irql_cascade (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic slv_ack_i,
    output logic pulse_o
);

    logic raised_q;
    logic pulse_q;

    // Fire once per pending episode; an acknowledge re-arms the generator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q  <= pend_i & ~raised_q;
            raised_q <= (raised_q & ~slv_ack_i) | (pend_i & ~raised_q);
        end
    end

    assign pulse_o = pulse_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);                                    // R7
    AST_NO_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (raised_q && !slv_ack_i) |=> !pulse_q);                   // R7

endmodule

// File: rtl/irq_req_latch.sv
// Module: top of the two-unit interrupt request latch.
// Assumes lines are asynchronous; configuration and acknowledge are synchronous to clk.
module irq_req_latch #(
    parameter int             NPIN   = 8,
    parameter logic [NPIN-1:0] MST_OK = 8'hF8,
    parameter logic [NPIN-1:0] SLV_OK = 8'hDE,
    localparam int            PW     = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] mst_pin_i,
    input  logic [NPIN-1:0] slv_pin_i,
    input  logic            cfg_we_i,
    input  logic            cfg_unit_i,
    input  logic [NPIN-1:0] cfg_wdata_i,
    output logic [NPIN-1:0] cfg_rdata_o,
    input  logic            ack_i,
    input  logic            ack_unit_i,
    input  logic [PW-1:0]   ack_pin_i,
    input  logic            slv_pending_i,
    output logic [NPIN-1:0] mst_req_o,
    output logic [NPIN-1:0] slv_req_o
);
    import irql_pkg::*;

    localparam logic [NPIN-1:0] CASC_BIT = {{(NPIN-1){1'b0}}, 1'b1} << IRQL_CASC_PIN;

    logic [NPIN-1:0] mst_sync, slv_sync, mst_line;
    logic [NPIN-1:0] mst_lvl, slv_lvl;
    logic [NPIN-1:0] ack_oh, mst_ack, slv_ack;
    logic            casc_pulse, slv_ack_any;

    irql_sync #(.W(NPIN)) u_sync_mst (
        .clk(clk), .rst_n(rst_n), .async_i(mst_pin_i), .sync_o(mst_sync));
    irql_sync #(.W(NPIN)) u_sync_slv (
        .clk(clk), .rst_n(rst_n), .async_i(slv_pin_i), .sync_o(slv_sync));

    irql_trig_reg #(.NPIN(NPIN), .MST_OK(MST_OK), .SLV_OK(SLV_OK)) u_trig (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .unit_i(cfg_unit_i),
        .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
        .mst_lvl_o(mst_lvl), .slv_lvl_o(slv_lvl));

    // Decode the acknowledge into per-unit one-hot vectors.
    always_comb begin
        ack_oh = '0;
        ack_oh[ack_pin_i] = 1'b1;
        slv_ack_any = ack_i && (ack_unit_i == UNIT_SLV);
        slv_ack = slv_ack_any ? ack_oh : '0;
        if (slv_ack_any)
            mst_ack = CASC_BIT;
        else if (ack_i)
            mst_ack = ack_oh;
        else
            mst_ack = '0;
    end

    irql_cascade u_casc (
        .clk(clk), .rst_n(rst_n), .pend_i(slv_pending_i),
        .slv_ack_i(slv_ack_any), .pulse_o(casc_pulse));

    // Merge the cascade pulse onto the primary cascade line.
    assign mst_line = mst_sync | (casc_pulse ? CASC_BIT : '0);

    irql_unit #(.NPIN(NPIN)) u_mst (
        .clk(clk), .rst_n(rst_n), .line_i(mst_line), .lvl_i(mst_lvl),
        .ack_vec_i(mst_ack), .req_o(mst_req_o));
    irql_unit #(.NPIN(NPIN)) u_slv (
        .clk(clk), .rst_n(rst_n), .line_i(slv_sync), .lvl_i(slv_lvl),
        .ack_vec_i(slv_ack), .req_o(slv_req_o));

    AST_CASC_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_lvl & CASC_BIT) == '0);                                               // R3
    AST_SLV_ACK_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_ack_any && !mst_line[IRQL_CASC_PIN]) |=> !mst_req_o[IRQL_CASC_PIN]); // R6

endmodule

// File: tb/irq_req_latch_tb_top.sv
`timescale 1ns/1ps
module irq_req_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] mst_pin, slv_pin, cfg_wdata, cfg_rdata, mst_req, slv_req;
    logic       cfg_we, cfg_unit, ack, ack_unit, slv_pending;
    logic [2:0] ack_pin;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_req_latch dut_i (
        .clk(clk), .rst_n(rst_n), .mst_pin_i(mst_pin), .slv_pin_i(slv_pin),
        .cfg_we_i(cfg_we), .cfg_unit_i(cfg_unit), .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata), .ack_i(ack), .ack_unit_i(ack_unit),
        .ack_pin_i(ack_pin), .slv_pending_i(slv_pending),
        .mst_req_o(mst_req), .slv_req_o(slv_req));

    // Vectors {mst_pins, slv_pins, exp_mst_req, exp_slv_req}; primary level on 3..7, secondary on 1-4,6,7.
    localparam logic [31:0] VEC [6] = '{
        {8'h09, 8'h21, 8'h09, 8'h21},
        {8'h00, 8'h00, 8'h01, 8'h21},
        {8'hF0, 8'h12, 8'hF1, 8'h33},
        {8'h00, 8'h00, 8'h01, 8'h21},
        {8'h02, 8'h80, 8'h03, 8'hA1},
        {8'h00, 8'h00, 8'h03, 8'h21}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_ack(input logic unit, input logic [2:0] pin);
        @(negedge clk);
        ack = 1'b1; ack_unit = unit; ack_pin = pin;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; mst_pin = '0; slv_pin = '0; cfg_we = 1'b0; cfg_unit = 1'b0;
        cfg_wdata = '0; ack = 1'b0; ack_unit = 1'b0; ack_pin = '0; slv_pending = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 mst_req", mst_req, 8'h00);
        check("R9 slv_req", slv_req, 8'h00);
        cfg_unit = 1'b0; #0.1;
        check("R9 mst trig", cfg_rdata, 8'h00);
        cfg_unit = 1'b1; #0.1;
        check("R9 slv trig", cfg_rdata, 8'h00);

        // R3: masked writes
        @(negedge clk);
        cfg_we = 1'b1; cfg_unit = 1'b0; cfg_wdata = 8'hFF;
        @(negedge clk);
        cfg_unit = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_unit = 1'b0; #0.1;
        check("R3 R4 mst trig", cfg_rdata, 8'hF8);
        cfg_unit = 1'b1; #0.1;
        check("R3 R4 slv trig", cfg_rdata, 8'hDE);

        // R1 R2 R3: table walk
        foreach (VEC[k]) begin
            @(negedge clk);
            mst_pin = VEC[k][31:24];
            slv_pin = VEC[k][23:16];
            wait_cyc(4);
            check($sformatf("R1 R2 R3 vec%0d mst", k), mst_req, VEC[k][15:8]);
            check($sformatf("R1 R2 R3 vec%0d slv", k), slv_req, VEC[k][7:0]);
        end

        // R5 R6: acknowledges with lines low
        do_ack(1'b0, 3'd0);
        check("R5 ack mst0", mst_req, 8'h02);
        do_ack(1'b0, 3'd1);
        check("R5 ack mst1", mst_req, 8'h00);
        do_ack(1'b1, 3'd0);
        check("R6 ack slv0", slv_req, 8'h20);
        do_ack(1'b1, 3'd5);
        check("R6 ack slv5", slv_req, 8'h00);

        // R5: ack of a high level line keeps it
        @(negedge clk); mst_pin = 8'h10;
        wait_cyc(4);
        do_ack(1'b0, 3'd4);
        check("R5 ack high level", mst_req, 8'h10);
        mst_pin = 8'h00;
        wait_cyc(4);
        check("R2 level drop", mst_req, 8'h00);

        // R5: ack in the same cycle as a rising edge
        @(negedge clk); mst_pin = 8'h01;
        @(posedge clk); @(posedge clk);
        @(negedge clk); ack = 1'b1; ack_unit = 1'b0; ack_pin = 3'd0;
        @(posedge clk);
        @(negedge clk); ack = 1'b0;
        check("R5 ack with rise", mst_req, 8'h01);
        mst_pin = 8'h00;

        // R8: latency of three edges
        @(negedge clk); slv_pin = 8'h20;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8 not yet", slv_req, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R8 set", slv_req, 8'h20);
        slv_pin = 8'h00;

        // R7: cascade pulse onto primary line 2
        wait_cyc(3);
        slv_pending = 1'b1;
        wait_cyc(4);
        check("R7 cascade set", mst_req & 8'h04, 8'h04);
        do_ack(1'b0, 3'd2);
        wait_cyc(4);
        check("R7 no repulse", mst_req & 8'h04, 8'h00);
        do_ack(1'b1, 3'd3);
        wait_cyc(4);
        check("R7 R6 rearm", mst_req & 8'h04, 8'h04);
        slv_pending = 1'b0;
        do_ack(1'b1, 3'd3);
        check("R6 slv ack clears casc", mst_req & 8'h04, 8'h00);

        // R9: mid-run reset
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rerun mst", mst_req, 8'h00);
        check("R9 rerun slv", slv_req, 8'h00);
        cfg_unit = 1'b0; #0.1;
        check("R9 rerun trig", cfg_rdata, 8'h00);

        done = 1;
        finish_run();
    end

endmodule